// File: doc/BRIEF.md
# Programmable-Tap Self-Synchronizing Bit Scrambler

This block whitens a serial bit stream by polynomial division over a seven-stage delay line. For every accepted bit, the stages picked out by a runtime tap mask are XORed together. That feedback bit is XORed with the incoming bit to give the output bit. In scramble mode the output bit (the quotient) is pushed into the delay line. In descramble mode the received bit is pushed in instead, so a descrambler with the same mask and seed recovers the original stream.

A start-of-packet pulse reloads the delay line with a fixed nonzero seed, so every packet begins from a known state. Bits are presented one per cycle with a valid strobe. The result appears on a registered output one cycle later, with its own valid flag. Framing, rate control and modulation belong to neighbouring blocks.

Top module: `ptap_scrambler`

## Requirements
- R1: After reset, `out_valid` and `out_bit` are 0 and the delay line holds the seed 0x6C.
- R2: For an accepted bit, the output bit equals `in_bit` XOR the XOR-sum of the delay-line stages whose `tap_mask` bit is set.
- R3: In scramble mode (`descramble` = 0), each accepted bit shifts the produced output bit into stage z^-1, and older stages move one place deeper.
- R4: In descramble mode (`descramble` = 1), each accepted bit shifts the received `in_bit` into stage z^-1. A stream scrambled and then descrambled from the same seed and mask comes back unchanged.
- R5: A `sop` pulse loads the seed 0x6C, where seed bit k is stage z^-(k+1), and overrides the old contents. If `in_valid` is high in the same cycle, the seed is the state used for that bit, and the bit is then shifted in on top of it.
- R6: While `in_valid` and `sop` are both low, the delay line does not move, `out_bit` holds its last value, and `out_valid` is 0.
- R7: `out_valid` equals `in_valid` delayed by one clock, and `out_bit` carries the result for the bit accepted in the previous cycle.
- R8: With `tap_mask` = 0, the output bit equals the input bit.
- R9: `tap_mask` bit k selects stage z^-(k+1), which is the k-th most recent bit shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop | input | 1 | Start-of-packet: reload the seed |
| descramble | input | 1 | 0 = scramble, 1 = descramble |
| tap_mask | input | 7 | Feedback tap selection, bit k = stage z^-(k+1) |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit strobe, one cycle after `in_valid` |
| out_bit | output | 1 | Serial output bit |

## Verification
An all-zero mask shows the pass-through path. Masks with a single tap, applied right after a seed load, reveal the stage ordering and the seed bit positions, because the first output is just the input XOR one seed bit. Long streams of all zeros, all ones, alternating bits and pseudo-random bits are run under a multi-tap mask; all-zeros exposes the raw feedback sequence, while the others separate scramble-mode shifting from descramble-mode shifting. Gaps in the valid strobe, a round trip through the descrambler, and a seed load coinciding with a valid bit check the hold, inversion and seed-priority rules.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int unsigned SCR_LEN = 7;
    localparam logic [SCR_LEN-1:0] SCR_SEED = 7'h6C;

    typedef struct packed {
        logic vld;
        logic bit_o;
    } scr_out_t;
endpackage

// File: rtl/scr_parity.sv
module scr_parity #(
    parameter int unsigned LEN = 7
) (
    input  logic [LEN-1:0] stages,
    input  logic [LEN-1:0] mask,
    output logic           fb
);
    logic acc;

    always_comb begin
        acc = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            acc = acc ^ (stages[k] & mask[k]);
        end
    end

    assign fb = acc;
endmodule

// File: rtl/scr_state.sv
module scr_state #(
    parameter int unsigned     LEN  = 7,
    parameter logic [LEN-1:0]  SEED = 7'h6C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           adv,
    input  logic           new_bit,
    output logic [LEN-1:0] cur,
    output logic [LEN-1:0] state_q
);
    logic [LEN-1:0] state_d;

    // Seed substitutes for the stored contents during a load cycle
    assign cur = load ? SEED : state_q;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            state_d = {cur[LEN-2:0], new_bit};
        end else if (load) begin
            state_d = SEED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(state_q))
        else $error("delay line moved without a strobe");

    p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !adv) |=> (state_q == SEED))
        else $error("seed not loaded");
endmodule

// File: rtl/ptap_scrambler.sv
module ptap_scrambler
    import scr_pkg::*;
#(
    parameter int unsigned        LEN  = SCR_LEN,
    parameter logic [LEN-1:0]     SEED = SCR_SEED
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sop,
    input  logic           descramble,
    input  logic [LEN-1:0] tap_mask,
    input  logic           in_valid,
    input  logic           in_bit,
    output logic           out_valid,
    output logic           out_bit
);
    logic [LEN-1:0] cur_state;
    logic [LEN-1:0] state_q;
    logic           fb;
    logic           scr_bit;
    logic           push_bit;
    scr_out_t       out_d, out_q;

    scr_state #(.LEN(LEN), .SEED(SEED)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sop),
        .adv     (in_valid),
        .new_bit (push_bit),
        .cur     (cur_state),
        .state_q (state_q)
    );

    scr_parity #(.LEN(LEN)) u_parity (
        .stages (cur_state),
        .mask   (tap_mask),
        .fb     (fb)
    );

    assign scr_bit  = in_bit ^ fb;
    assign push_bit = descramble ? in_bit : scr_bit;

    always_comb begin
        out_d       = out_q;
        out_d.vld   = in_valid;
        if (in_valid) begin
            out_d.bit_o = scr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_bit   = out_q.bit_o;

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid latency broken");

    p_pass_thru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tap_mask == '0) |=> (out_bit == $past(in_bit)))
        else $error("zero mask altered data");

    p_quot_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !descramble) |=> (state_q[0] == out_bit))
        else $error("output bit not fed back");

    p_rx_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && descramble) |=> (state_q[0] == $past(in_bit)))
        else $error("received bit not fed back");
endmodule

// File: tb/test_ptap_scrambler.sv
module test_ptap_scrambler;
    localparam logic [6:0] SEED = 7'h6C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sop = 1'b0;
    logic       descramble = 1'b0;
    logic [6:0] tap_mask = '0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       out_valid;
    logic       out_bit;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] m = SEED;
    logic       prev_out = 1'b0;
    logic       last_o;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    ptap_scrambler i_ptap_scrambler (
        .clk(clk), .rst_n(rst_n), .sop(sop), .descramble(descramble),
        .tap_mask(tap_mask), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, update the model, check registered outputs after the edge
    task automatic step(input logic v, input logic b, input logic s, input logic d,
                        input logic [6:0] mask, input string req);
        logic [6:0] st;
        logic       o;
        @(negedge clk);
        sop = s; descramble = d; tap_mask = mask; in_valid = v; in_bit = b;
        st = s ? SEED : m;
        o  = b ^ (^(st & mask));
        if (v) m = {st[5:0], d ? b : o};
        else if (s) m = SEED;
        @(posedge clk); #1;
        chk({req, " valid"}, {6'd0, out_valid}, {6'd0, v});
        if (v) begin
            chk(req, {6'd0, out_bit}, {6'd0, o});
            prev_out = o;
        end else begin
            chk(req, {6'd0, out_bit}, {6'd0, prev_out});
        end
        last_o = o;
        @(negedge clk);
        sop = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 out_valid", {6'd0, out_valid}, 7'd0);
        chk("R1 out_bit", {6'd0, out_bit}, 7'd0);
        rst_n = 1'b1;
        m = SEED;
        // Full mask after reset: first output is in ^ parity(seed)
        step(1'b1, 1'b0, 1'b0, 1'b0, 7'h7F, "R1 seed after reset");
    endtask

    task automatic t_zero_mask;
        for (int i = 0; i < 12; i++)
            step(1'b1, 1'((i * 5 + 3) % 3 == 0), 1'b0, 1'b0, 7'h00, "R8 pass through");
    endtask

    task automatic t_single_taps;
        for (int k = 0; k < 7; k++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0, 7'(1 << k), "R9 single tap");
            chk("R9 seed bit", {6'd0, last_o}, {6'd0, SEED[k]});
        end
        // Tap on z^-1 after a known bit: output reflects the bit just pushed
        step(1'b1, 1'b1, 1'b1, 1'b0, 7'h00, "R9 prime");
        step(1'b1, 1'b0, 1'b0, 1'b0, 7'h01, "R9 z1 tap");
        chk("R9 z1 value", {6'd0, last_o}, 7'd1);
    endtask

    task automatic t_streams;
        logic [15:0] lf = 16'hACE1;
        for (int p = 0; p < 4; p++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0, 7'h48, "R5 packet start");
            for (int i = 0; i < 40; i++) begin
                logic b;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                case (p)
                    0: b = 1'b0;
                    1: b = 1'b1;
                    2: b = 1'(i % 2);
                    default: b = lf[0];
                endcase
                step(1'b1, b, 1'b0, 1'b0, 7'h48, "R2 R3 scramble stream");
            end
        end
    endtask

    task automatic t_roundtrip;
        logic src [48];
        logic enc [48];
        logic [15:0] lf = 16'h1D0F;
        step(1'b1, 1'b0, 1'b1, 1'b0, 7'h09, "R5 tx start");
        src[0] = 1'b0; enc[0] = last_o;
        for (int i = 1; i < 48; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[14] ^ lf[12] ^ lf[3]};
            src[i] = lf[0];
            step(1'b1, src[i], 1'b0, 1'b0, 7'h09, "R3 tx");
            enc[i] = last_o;
        end
        step(1'b1, enc[0], 1'b1, 1'b1, 7'h09, "R4 rx start");
        chk("R4 recover", {6'd0, last_o}, {6'd0, src[0]});
        for (int i = 1; i < 48; i++) begin
            step(1'b1, enc[i], 1'b0, 1'b1, 7'h09, "R4 rx");
            chk("R4 recover", {6'd0, last_o}, {6'd0, src[i]});
        end
    endtask

    task automatic t_idle;
        step(1'b1, 1'b1, 1'b1, 1'b0, 7'h5B, "R5 start");
        step(1'b1, 1'b0, 1'b0, 1'b0, 7'h5B, "R2");
        for (int g = 0; g < 5; g++) begin
            step(1'b0, 1'(g % 2), 1'b0, 1'b0, 7'h5B, "R6 idle hold");
        end
        for (int i = 0; i < 10; i++)
            step(1'b1, 1'(i % 3 == 0), 1'b0, 1'b0, 7'h5B, "R6 resume R7");
        // Seed load with no data, then data: seed used as state
        step(1'b0, 1'b0, 1'b1, 1'b0, 7'h5B, "R5 bare load");
        step(1'b1, 1'b1, 1'b0, 1'b0, 7'h5B, "R5 after load");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #20;
        t_reset();
        t_zero_mask();
        t_single_taps();
        t_streams();
        t_roundtrip();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule